// File: doc/BRIEF.md
# Frequency Synthesis Loop Digital Core

This block holds the counting and comparing logic of a frequency-synthesis loop. It runs on one system clock and watches two free-running square waves: a reference oscillator and the RF signal after an external divide-by-eight stage. Both are brought into the clock domain by flop chains, and only their rising edges are counted. A reference counter emits a strobe every 512 or every 1024 reference edges. A 15-bit programmable counter emits a strobe every N RF edges. In narrow mode the top ratio bit is forced to zero, and any ratio below 256 is raised to 256.

A tri-state phase/frequency detector compares the two strobes. It requests pump-up when the reference strobe leads, pump-down when the divided RF strobe leads, and neither when both arrive together. A lock monitor drives an active-low lock flag. The flag rises as soon as a pump request lasts too long. It falls only at a reference strobe that closes a whole reference period free of such events. Both divider strobes are brought out for observation, and a pump-current select is registered to an output that steers the external charge pump.

Top module: `pll_synth_core`

## Requirements
- R1: `ref_tp` is a one-cycle strobe that repeats every 512 rising edges of `ref_in` when `ref_long`=0 and every 1024 when `ref_long`=1.
- R2: `fd_tp` is a one-cycle strobe that repeats every N rising edges of `rf_in`. N is `ratio` when `ratio_wide`=1 and `{0, ratio[13:0]}` when `ratio_wide`=0, so bit 14 is ignored in narrow mode. A new N is sampled at each `fd_tp` and governs the period that follows.
- R3: An effective ratio below 256 is replaced by 256. After reset the first programmable period uses 256.
- R4: A `ref_tp` in cycle c raises `up` from c+1 until the cycle after the next `fd_tp`. An `fd_tp` leading `ref_tp` raises `dn` in the same way. Strobes in the same cycle raise neither, and `up` and `dn` are never high together.
- R5: If `up` or `dn` is high in cycles k through k+LOCK_TOL, `lock_n` is high at cycle k+LOCK_TOL+2 at the latest.
- R6: `lock_n` falls only in the cycle after a `ref_tp`, and only when the whole reference period before it held no R5 event. After reset it stays high at least until the second `ref_tp`.
- R7: `pump_hi` equals `pump_sel` delayed by one clock.
- R8: During and right after reset, `up`, `dn`, `ref_tp`, `fd_tp` and `pump_hi` are 0 and `lock_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rf_in | input | 1 | Prescaled RF square wave, asynchronous |
| ref_in | input | 1 | Reference oscillator square wave, asynchronous |
| ratio | input | 15 | Programmable divider ratio |
| ratio_wide | input | 1 | 1: use all 15 ratio bits; 0: bit 14 forced low |
| ref_long | input | 1 | 0: reference ratio 512; 1: reference ratio 1024 |
| pump_sel | input | 1 | Charge-pump current select (1 = high current) |
| up | output | 1 | Pump-up request |
| dn | output | 1 | Pump-down request |
| lock_n | output | 1 | Lock flag, low when locked |
| pump_hi | output | 1 | Registered pump-current select |
| ref_tp | output | 1 | Reference divider strobe, for observation |
| fd_tp | output | 1 | Programmable divider strobe, for observation |

## Verification
The properties assume that each of `rf_in` and `ref_in` holds every level for at least one full clock. Otherwise the edge detectors would drop edges and the strobe spacing and lock timing would not follow the requirements. The stimulus derives both waves from one counter that steps on the falling clock edge, so every level lasts a whole number of cycles and the edge spacing is two, four or eight cycles. The properties also assume that `ratio`, `ratio_wide` and `ref_long` change only between strobes. The bench changes them only right after it has observed the matching strobe.

// File: rtl/pll_core_pkg.sv
package pll_core_pkg;
    localparam int DIV_W      = 15;
    localparam int MIN_RATIO  = 256;
    localparam int REF_SHORT  = 512;
    localparam int REF_LONG   = 1024;
    localparam int SYNC_DEPTH = 2;
    localparam int LOCK_TOL   = 4;
endpackage

// File: rtl/pll_edge_sync.sv
module pll_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic [STAGES:0] chain;
        logic            rise;
    } sync_t;

    sync_t s_q, s_d;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-1:0], din};
        // new level reached the last sync stage and differs from history
        s_d.rise  = s_q.chain[STAGES-1] & ~s_q.chain[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise = s_q.rise;
endmodule

// File: rtl/pll_ref_div.sv
module pll_ref_div #(
    parameter int SHORT_RATIO = 512,
    parameter int LONG_RATIO  = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_in,
    input  logic long_sel,
    output logic stb
);
    localparam int CW = $clog2(LONG_RATIO);
    localparam logic [CW-1:0] LIM_S = CW'(SHORT_RATIO - 1);
    localparam logic [CW-1:0] LIM_L = CW'(LONG_RATIO - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          stb;
    } rdiv_t;

    rdiv_t s_q, s_d;
    logic [CW-1:0] lim;

    always_comb begin
        s_d     = s_q;
        s_d.stb = 1'b0;
        lim     = long_sel ? LIM_L : LIM_S;
        if (edge_in) begin
            if (s_q.cnt >= lim) begin
                s_d.cnt = '0;
                s_d.stb = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stb = s_q.stb;
endmodule

// File: rtl/pll_prog_div.sv
module pll_prog_div #(
    parameter int W       = 15,
    parameter int MIN_VAL = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         edge_in,
    input  logic [W-1:0] ratio,
    input  logic         wide,
    output logic         stb,
    output logic [W-1:0] cur_ratio
);
    localparam logic [W-1:0] MIN_V = W'(MIN_VAL);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] n;
        logic         stb;
    } pdiv_t;

    pdiv_t s_q, s_d;
    logic [W-1:0] eff;

    always_comb begin
        eff = wide ? ratio : {1'b0, ratio[W-2:0]};
        if (eff < MIN_V) eff = MIN_V;

        s_d     = s_q;
        s_d.stb = 1'b0;
        if (edge_in) begin
            if (s_q.cnt == s_q.n - 1'b1) begin
                s_d.cnt = '0;
                s_d.stb = 1'b1;
                s_d.n   = eff;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.n   <= MIN_V;
            s_q.stb <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stb       = s_q.stb;
    assign cur_ratio = s_q.n;
endmodule

// File: rtl/pll_pfd_lock.sv
module pll_pfd_lock #(
    parameter int TOL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_stb,
    input  logic fd_stb,
    output logic up,
    output logic dn,
    output logic lock_n
);
    localparam int PW = $clog2(TOL + 2);
    localparam logic [PW-1:0] TOL_V = PW'(TOL);
    localparam logic [PW-1:0] SAT_V = PW'(TOL + 1);

    typedef struct packed {
        logic          up;
        logic          dn;
        logic [PW-1:0] pw;
        logic          armed;
        logic          bad;
        logic          lock_n;
    } pfd_t;

    pfd_t s_q, s_d;
    logic nxt_up, nxt_dn, viol;

    always_comb begin
        s_d = s_q;

        // edge-set flags, cleared together once both are set
        nxt_up = s_q.up | ref_stb;
        nxt_dn = s_q.dn | fd_stb;
        if (nxt_up && nxt_dn) begin
            s_d.up = 1'b0;
            s_d.dn = 1'b0;
        end else begin
            s_d.up = nxt_up;
            s_d.dn = nxt_dn;
        end

        // width of the pump request in progress, saturating
        if (s_q.up || s_q.dn) s_d.pw = (s_q.pw == SAT_V) ? s_q.pw : s_q.pw + 1'b1;
        else                  s_d.pw = '0;

        viol = (s_q.pw > TOL_V);

        if (ref_stb) begin
            s_d.armed = 1'b1;
            s_d.bad   = viol;
            if (s_q.armed && !s_q.bad && !viol) s_d.lock_n = 1'b0;
        end else begin
            s_d.bad = s_q.bad | viol;
        end
        if (viol) s_d.lock_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.lock_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign up     = s_q.up;
    assign dn     = s_q.dn;
    assign lock_n = s_q.lock_n;
endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core
    import pll_core_pkg::*;
#(
    parameter int LOCK_TOL_P = LOCK_TOL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rf_in,
    input  logic             ref_in,
    input  logic [DIV_W-1:0] ratio,
    input  logic             ratio_wide,
    input  logic             ref_long,
    input  logic             pump_sel,
    output logic             up,
    output logic             dn,
    output logic             lock_n,
    output logic             pump_hi,
    output logic             ref_tp,
    output logic             fd_tp
);
    localparam int N_IN = 2;

    logic [N_IN-1:0]  raw_in;
    logic [N_IN-1:0]  rise;
    logic             ref_stb, fd_stb;
    logic [DIV_W-1:0] fd_ratio;

    typedef struct packed {
        logic pump;
    } top_t;
    top_t t_q, t_d;

    assign raw_in = {rf_in, ref_in};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        pll_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[g]),
            .rise  (rise[g])
        );
    end

    pll_ref_div #(.SHORT_RATIO(REF_SHORT), .LONG_RATIO(REF_LONG)) u_rdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_in  (rise[0]),
        .long_sel (ref_long),
        .stb      (ref_stb)
    );

    pll_prog_div #(.W(DIV_W), .MIN_VAL(MIN_RATIO)) u_pdiv (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_in   (rise[1]),
        .ratio     (ratio),
        .wide      (ratio_wide),
        .stb       (fd_stb),
        .cur_ratio (fd_ratio)
    );

    pll_pfd_lock #(.TOL(LOCK_TOL_P)) u_pfd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_stb (ref_stb),
        .fd_stb  (fd_stb),
        .up      (up),
        .dn      (dn),
        .lock_n  (lock_n)
    );

    always_comb begin
        t_d      = t_q;
        t_d.pump = pump_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign pump_hi = t_q.pump;
    assign ref_tp  = ref_stb;
    assign fd_tp   = fd_stb;
endmodule

// File: rtl/pll_synth_core_chk.sv
module pll_synth_core_chk #(
    parameter int TOL   = 4,
    parameter int W     = 15,
    parameter int MIN_R = 256
) (
    input logic         clk,
    input logic         rst_n,
    input logic         up,
    input logic         dn,
    input logic         lock_n,
    input logic         ref_tp,
    input logic         fd_tp,
    input logic         pump_sel,
    input logic         pump_hi,
    input logic [W-1:0] fd_ratio
);
    localparam int RW = $clog2(TOL + 2);
    logic [RW-1:0] run_q;
    logic          live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
            if (up || dn) run_q <= (run_q == RW'(TOL + 1)) ? run_q : run_q + 1'b1;
            else          run_q <= '0;
        end
    end

    p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n) !(up && dn));
    p_unlock_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((up || dn) && run_q == RW'(TOL + 1)) |=> lock_n);
    p_lock_at_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> $past(ref_tp));
    p_ref_single_r1: assert property (@(posedge clk) disable iff (!rst_n) ref_tp |=> !ref_tp);
    p_fd_single_r2: assert property (@(posedge clk) disable iff (!rst_n) fd_tp |=> !fd_tp);
    p_ratio_floor_r3: assert property (@(posedge clk) disable iff (!rst_n) fd_ratio >= W'(MIN_R));
    p_pump_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (pump_hi == $past(pump_sel)));
endmodule

bind pll_synth_core pll_synth_core_chk #(
    .TOL   (LOCK_TOL_P),
    .W     (pll_core_pkg::DIV_W),
    .MIN_R (pll_core_pkg::MIN_RATIO)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up       (up),
    .dn       (dn),
    .lock_n   (lock_n),
    .ref_tp   (ref_tp),
    .fd_tp    (fd_tp),
    .pump_sel (pump_sel),
    .pump_hi  (pump_hi),
    .fd_ratio (fd_ratio)
);

// File: tb/sim_pll_synth_core.sv
`timescale 1ns/1ps
module sim_pll_synth_core;
    localparam int TOL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rf_in = 1'b0, ref_in = 1'b0;
    logic [14:0] ratio = 15'd256;
    logic        ratio_wide = 1'b0, ref_long = 1'b0, pump_sel = 1'b0;
    logic        up, dn, lock_n, pump_hi, ref_tp, fd_tp;

    int n_tests = 0, n_fail = 0;
    int cyc = 0, start_cyc = 0;
    int gen_on = 0, t = 0, ref_sh = 0, rf_sh = 1, rf_dly = 0;
    int meas_on = 0, up_cnt = 0, dn_cnt = 0, run = 0, imm_armed = 0;

    always #2.5 clk = ~clk;

    pll_synth_core #(.LOCK_TOL_P(TOL)) u0 (
        .clk(clk), .rst_n(rst_n), .rf_in(rf_in), .ref_in(ref_in),
        .ratio(ratio), .ratio_wide(ratio_wide), .ref_long(ref_long),
        .pump_sel(pump_sel), .up(up), .dn(dn), .lock_n(lock_n),
        .pump_hi(pump_hi), .ref_tp(ref_tp), .fd_tp(fd_tp)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // square-wave sources from one counter, stepped on the falling edge
    always @(negedge clk) begin
        if (gen_on == 0) begin
            t = 0; ref_in = 1'b0; rf_in = 1'b0;
        end else begin
            ref_in = ((t >> ref_sh) & 1) != 0;
            rf_in  = (t >= rf_dly) ? (((t - rf_dly) >> rf_sh) & 1) != 0 : 1'b0;
            t = t + 1;
        end
    end

    task automatic check(input string req, input logic ok, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // pump-request monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (meas_on != 0) begin
            if (up) up_cnt++;
            if (dn) dn_cnt++;
            if (up || dn) run++; else run = 0;
            if (imm_armed != 0 && run == TOL + 3) begin
                check("R5 lock_n high right after long pump pulse", lock_n == 1'b1, lock_n, 1);
                imm_armed = 0;
            end
        end
    end

    initial begin
        #950000;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic restart();
        gen_on = 0; meas_on = 0;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        start_cyc = cyc;
        gen_on = 1;
    endtask

    task automatic wait_strobe(input int which, output int at);
        do @(negedge clk); while ((which == 0 ? ref_tp : fd_tp) !== 1'b1);
        at = cyc;
    endtask

    task automatic clear_meas();
        up_cnt = 0; dn_cnt = 0; run = 0; meas_on = 1;
    endtask

    task automatic t_reset();
        gen_on = 0; pump_sel = 1'b1;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 up/dn low in reset", up == 0 && dn == 0, {up, dn}, 0);
        check("R8 lock_n high in reset", lock_n == 1'b1, lock_n, 1);
        check("R8 strobes low in reset", ref_tp == 0 && fd_tp == 0, {ref_tp, fd_tp}, 0);
        check("R8 pump_hi low in reset", pump_hi == 1'b0, pump_hi, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 outputs idle after reset", up == 0 && dn == 0 && lock_n == 1, {up, dn, lock_n}, 1);
    endtask

    task automatic t_pump();
        pump_sel = 1'b1; @(negedge clk);
        check("R7 pump_hi follows select high", pump_hi == 1'b1, pump_hi, 1);
        pump_sel = 1'b0; @(negedge clk);
        check("R7 pump_hi follows select low", pump_hi == 1'b0, pump_hi, 0);
    endtask

    task automatic t_ref_div();
        int a, b;
        ref_sh = 0; rf_sh = 1; rf_dly = 0; ref_long = 1'b0;
        restart();
        wait_strobe(0, a); wait_strobe(0, b);
        check("R1 ref period at 512", b - a == 1024, b - a, 1024);
        ref_long = 1'b1;
        wait_strobe(0, a); wait_strobe(0, b);
        check("R1 ref period at 1024", b - a == 2048, b - a, 2048);
        ref_long = 1'b0;
    endtask

    task automatic t_prog_div();
        int a, b;
        rf_sh = 0; rf_dly = 0; ref_sh = 0;
        ratio = 15'h4000 + 15'd300; ratio_wide = 1'b0;
        restart();
        wait_strobe(1, a);
        check("R3 first period after reset uses 256", (a - start_cyc) >= 512 && (a - start_cyc) <= 520, a - start_cyc, 512);
        wait_strobe(1, b);
        check("R2 narrow mode ignores bit 14", b - a == 600, b - a, 600);
        ratio_wide = 1'b1;
        wait_strobe(1, a); wait_strobe(1, b);
        check("R2 wide mode uses all 15 bits", b - a == 2 * 16684, b - a, 2 * 16684);
        ratio = 15'd100; ratio_wide = 1'b0;
        wait_strobe(1, a); wait_strobe(1, b);
        check("R3 small ratio clamped to 256", b - a == 512, b - a, 512);
        ratio = 15'd256;
    endtask

    // rf edge one cycle before ref edge: short dn pulses, loop locks
    task automatic t_lock_dn_lead();
        int fall;
        ratio = 15'd256; ratio_wide = 1'b0; ref_long = 1'b0;
        ref_sh = 0; rf_sh = 1; rf_dly = 0;
        restart(); clear_meas();
        repeat (1500) @(negedge clk);
        check("R6 still unlocked before second ref period", lock_n == 1'b1, lock_n, 1);
        fall = 0;
        while (fall == 0 && cyc - start_cyc < 2200) begin
            @(negedge clk);
            if (lock_n == 1'b0) fall = cyc - start_cyc;
        end
        check("R6 lock after one full clean ref period", fall >= 2040 && fall <= 2070, fall, 2050);
        repeat (3000) @(negedge clk);
        check("R4 rf lead gives dn only", up_cnt == 0 && dn_cnt > 0, up_cnt, 0);
        check("R4 dn width equals one-cycle phase error", dn_cnt >= 4 && dn_cnt <= 5, dn_cnt, 5);
        check("R6 lock held with small error", lock_n == 1'b0, lock_n, 0);

        // speed up rf: fd strobe leads by far, long dn pulses
        imm_armed = 1; clear_meas();
        rf_sh = 0;
        repeat (2500) @(negedge clk);
        check("R5 unlock flagged on fast rf", lock_n == 1'b1, lock_n, 1);
        check("R4 fast rf gives mostly dn", dn_cnt > up_cnt, dn_cnt, up_cnt);
        check("R5 immediate check was reached", imm_armed == 0, imm_armed, 0);
        meas_on = 0;
    endtask

    // ref edge one cycle before rf edge: up pulses of one cycle
    task automatic t_up_lead();
        ref_sh = 0; rf_sh = 1; rf_dly = 2;
        restart(); clear_meas();
        repeat (4200) @(negedge clk);
        check("R4 ref lead gives up only", dn_cnt == 0 && up_cnt > 0, dn_cnt, 0);
        check("R6 locks with one-cycle up error", lock_n == 1'b0, lock_n, 0);
        clear_meas();
        rf_sh = 2;
        repeat (5000) @(negedge clk);
        check("R4 slow rf gives mostly up", up_cnt > dn_cnt, up_cnt, dn_cnt);
        check("R5 unlock flagged on slow rf", lock_n == 1'b1, lock_n, 1);
        meas_on = 0;
    endtask

    // strobes land in the same cycle: no pump request at all
    task automatic t_coincident();
        ref_sh = 0; rf_sh = 1; rf_dly = 1;
        restart(); clear_meas();
        repeat (4200) @(negedge clk);
        check("R4 coincident strobes raise neither", up_cnt == 0 && dn_cnt == 0, up_cnt + dn_cnt, 0);
        check("R6 lock with zero phase error", lock_n == 1'b0, lock_n, 0);
        meas_on = 0;
    endtask

    initial begin
        t_reset();
        t_pump();
        t_ref_div();
        t_prog_div();
        t_lock_dn_lead();
        t_up_lead();
        t_coincident();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule